// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small, fully associative record of loads that were issued ahead of possibly conflicting stores. Every record is keyed by a destination register number and a register class bit (general or floating-point). It holds the byte address and access size of the early load. Later stores and atomic operations probe the table with their own address and size, and any record whose bytes they touch is dropped. A later check asks whether the record for a register is still present. A hit means the early load's data is still good. A miss means recovery is needed.

The block has two request channels. The command channel takes one operation per cycle: allocate, one of four check forms, invalidate-all, or invalidate-one. The store-probe channel takes one store per cycle and works on its own. Each check gets a registered hit/miss response one cycle later. When a store and a command arrive in the same cycle, the store is applied first. The table has a parameter number of slots. A new record goes into the slot already held by the same register if there is one, then into the lowest free slot, and otherwise into the slot named by a round-robin pointer.

Top module: `advld_table`

## Requirements
- R1: After reset every record is invalid. Until something is allocated, every check responds with a miss.
- R2: Allocate (cmd_op 1) creates a record keyed by register number and class bit. A check hits only when both the number and the class match a valid record.
- R3: Clearing load check (cmd_op 2) reports hit or miss. On a hit it removes the record. It never allocates.
- R4: Keeping load check (cmd_op 3) leaves a hit record in place. On a miss it allocates a record for that register from the request's address and size.
- R5: Keeping speculation check (cmd_op 5) reports hit or miss and never changes the table.
- R6: Clearing speculation check (cmd_op 4) removes a hit record and never allocates.
- R7: A store probe drops every record whose byte range [addr, addr + 2^size) overlaps the store's range [st_addr, st_addr + 2^st_size). Records at adjacent, non-overlapping bytes survive. Size codes 0..3 mean 1, 2, 4 and 8 bytes.
- R8: A store probe and a command in the same cycle see the store applied first. A check whose record the store overlaps therefore reports a miss.
- R9: Invalidate-all (cmd_op 6) drops every record in a single cycle.
- R10: Invalidate-one (cmd_op 7) drops only the record that matches the given register number and class.
- R11: Allocating for a register that already has a record reuses that slot, so no duplicates exist. Otherwise the lowest free slot is used. If the table is full, a round-robin pointer picks the victim and then advances.
- R12: A new or reused record takes every field from the current request. No address or size of the previous occupant survives.
- R13: Each check command produces rsp_valid exactly one cycle later, with rsp_hit. Commands 0, 1, 6 and 7 produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 none, 1 allocate, 2 load check clear, 3 load check keep, 4 spec check clear, 5 spec check keep, 6 invalidate all, 7 invalidate one |
| cmd_reg | input | REG_W | Destination register number |
| cmd_fp | input | 1 | Register class: 1 floating-point, 0 general |
| cmd_addr | input | ADDR_W | Load byte address |
| cmd_size | input | SIZE_W | Load size code, bytes = 2^code |
| st_valid | input | 1 | Store probe present this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | SIZE_W | Store size code, bytes = 2^code |
| rsp_valid | output | 1 | Check response valid |
| rsp_hit | output | 1 | Check found a live record |

## Verification
A store probe and a command can land in the same cycle. The bench creates this by driving st_valid in the same cycle as a clearing check, a keeping load check and an allocation, with overlapping and with adjacent addresses. A behavioural reference model applies the store to its records before it interprets the command. Its predicted hit is compared with rsp_hit one cycle later, and later keeping checks show whether the surviving or reallocated record is present. A long random run then mixes both channels freely, with a small register and address space, so that these collisions happen often.

// File: rtl/advld_pkg.sv
package advld_pkg;

   typedef enum logic [2:0] {
      OP_NONE       = 3'd0,
      OP_ALLOC      = 3'd1,
      OP_LDCHK_CLR  = 3'd2,
      OP_LDCHK_KEEP = 3'd3,
      OP_ACHK_CLR   = 3'd4,
      OP_ACHK_KEEP  = 3'd5,
      OP_INV_ALL    = 3'd6,
      OP_INV_ONE    = 3'd7
   } advld_op_e;

   function automatic logic op_is_check(input advld_op_e op);
      return (op == OP_LDCHK_CLR) || (op == OP_LDCHK_KEEP) ||
             (op == OP_ACHK_CLR)  || (op == OP_ACHK_KEEP);
   endfunction

   function automatic logic op_clears_hit(input advld_op_e op);
      return (op == OP_LDCHK_CLR) || (op == OP_ACHK_CLR) || (op == OP_INV_ONE);
   endfunction

endpackage

// File: rtl/advld_overlap.sv
module advld_overlap #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] a_base,
   input  logic [SIZE_W-1:0] a_lg,
   input  logic [ADDR_W-1:0] b_base,
   input  logic [SIZE_W-1:0] b_lg,
   output logic              hit
);
   localparam int SPAN_W = ADDR_W + 1;

   logic [SPAN_W-1:0] a_lo, a_hi, b_lo, b_hi;

   assign a_lo = {1'b0, a_base};
   assign b_lo = {1'b0, b_base};
   assign a_hi = a_lo + (SPAN_W'(1) << a_lg);
   assign b_hi = b_lo + (SPAN_W'(1) << b_lg);

   // half-open ranges meet when each starts before the other ends
   assign hit = (a_lo < b_hi) && (b_lo < a_hi);

endmodule

// File: rtl/advld_victim.sv
module advld_victim #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] live,
   input  logic [DEPTH-1:0] match,
   input  logic             take,
   output logic [DEPTH-1:0] slot
);
   logic [IDX_W-1:0] rr_q;
   logic [DEPTH-1:0] free_oh;
   logic [DEPTH-1:0] rr_oh;
   logic             any_free;
   logic             evict;

   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!live[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign any_free = |free_oh;
   assign rr_oh    = DEPTH'(1) << rr_q;
   assign evict    = take && !(|match) && !any_free;

   always_comb begin
      if (|match)        slot = match;
      else if (any_free) slot = free_oh;
      else               slot = rr_oh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (evict) begin
         rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   // R11
   slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $onehot(slot));

   // R11
   rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict |=> (rr_q != $past(rr_q)));

endmodule

// File: rtl/advld_table.sv
module advld_table
   import advld_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int REG_W  = 7,
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [REG_W-1:0]  cmd_reg,
   input  logic              cmd_fp,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   output logic              rsp_valid,
   output logic              rsp_hit
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("advld_table: DEPTH must be at least 2");
   end
   if (SIZE_W < 1 || SIZE_W > 3) begin : g_bad_size
      $error("advld_table: SIZE_W must lie in 1..3");
   end
   if (REG_W < 1 || ADDR_W < 8) begin : g_bad_width
      $error("advld_table: REG_W or ADDR_W too small");
   end

   advld_op_e op;
   assign op = advld_op_e'(cmd_op);

   logic [DEPTH-1:0]  vld_q;
   logic [REG_W-1:0]  reg_q  [DEPTH];
   logic              fp_q   [DEPTH];
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [SIZE_W-1:0] size_q [DEPTH];

   logic [DEPTH-1:0] st_hit;
   logic [DEPTH-1:0] live;
   logic [DEPTH-1:0] match;
   logic [DEPTH-1:0] slot;
   logic [DEPTH-1:0] write_sel;
   logic [DEPTH-1:0] clear_sel;
   logic             any_match;
   logic             is_check;
   logic             do_write;
   logic             do_clear;
   logic             do_flush;

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic ov;
      advld_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ov (
         .a_base (addr_q[i]),
         .a_lg   (size_q[i]),
         .b_base (st_addr),
         .b_lg   (st_size),
         .hit    (ov)
      );
      // store probe is resolved before the command looks at the table
      assign st_hit[i] = st_valid && vld_q[i] && ov;
      assign live[i]   = vld_q[i] && !st_hit[i];
      assign match[i]  = live[i] && (reg_q[i] == cmd_reg) && (fp_q[i] == cmd_fp);
   end

   assign any_match = |match;
   assign is_check  = cmd_valid && op_is_check(op);
   assign do_flush  = cmd_valid && (op == OP_INV_ALL);
   assign do_clear  = cmd_valid && op_clears_hit(op);
   assign do_write  = cmd_valid && ((op == OP_ALLOC) ||
                                    ((op == OP_LDCHK_KEEP) && !any_match));

   advld_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (live),
      .match (match),
      .take  (do_write),
      .slot  (slot)
   );

   assign write_sel = {DEPTH{do_write}} & slot;
   assign clear_sel = {DEPTH{do_clear}} & match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (do_flush)                      vld_q[i] <= 1'b0;
            else if (write_sel[i])             vld_q[i] <= 1'b1;
            else if (st_hit[i] || clear_sel[i]) vld_q[i] <= 1'b0;
         end
      end
   end

   // every field comes from the current request, never from the old occupant
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (write_sel[i]) begin
            reg_q[i]  <= cmd_reg;
            fp_q[i]   <= cmd_fp;
            addr_q[i] <= cmd_addr;
            size_q[i] <= cmd_size;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
      end else begin
         rsp_valid <= is_check;
         rsp_hit   <= is_check && any_match;
      end
   end

   // R2
   match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R1
   empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_check && (vld_q == '0)) |=> !rsp_hit);

   // R13
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_flush |=> (vld_q == '0));

   // R3
   clr_hit_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (op == OP_LDCHK_CLR) && any_match) |=>
         ($countones(vld_q) < $countones($past(vld_q))));

   // R5
   keep_check_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (op == OP_ACHK_KEEP) && !st_valid) |=> (vld_q == $past(vld_q)));

   // R8
   store_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_check && ((st_hit & vld_q) == vld_q)) |=> !rsp_hit);

endmodule

// File: tb/advld_table_tb.sv
module advld_table_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 16;
   localparam int REG_W  = 7;
   localparam int ADDR_W = 32;
   localparam int SIZE_W = 2;

   localparam int NONE = 0, ALLOC = 1, LCLR = 2, LKEEP = 3,
                  ACLR = 4, AKEEP = 5, INVALL = 6, INVONE = 7;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cmd_valid;
   logic [2:0]        cmd_op;
   logic [REG_W-1:0]  cmd_reg;
   logic              cmd_fp;
   logic [ADDR_W-1:0] cmd_addr;
   logic [SIZE_W-1:0] cmd_size;
   logic              st_valid;
   logic [ADDR_W-1:0] st_addr;
   logic [SIZE_W-1:0] st_size;
   logic              rsp_valid;
   logic              rsp_hit;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // reference model state
   bit     m_v    [DEPTH];
   int     m_reg  [DEPTH];
   bit     m_fp   [DEPTH];
   longint m_addr [DEPTH];
   int     m_size [DEPTH];
   int     m_rr;

   always #(CLK_PERIOD/2) clk = ~clk;

   advld_table #(.DEPTH(DEPTH), .REG_W(REG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_fp(cmd_fp),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size),
      .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit)
   );

   function automatic bit ranges_meet(longint a, int as, longint b, int bs);
      return (a < b + (64'd1 << bs)) && (b < a + (64'd1 << as));
   endfunction

   task automatic model_step(input int op, input int rg, input bit fp, input longint ad,
                             input int sz, input bit sv, input longint sa, input int ss,
                             output bit ev, output bit eh);
      int mi;
      int sl;
      if (sv)
         for (int i = 0; i < DEPTH; i++)
            if (m_v[i] && ranges_meet(m_addr[i], m_size[i], sa, ss)) m_v[i] = 0;
      mi = -1;
      for (int i = 0; i < DEPTH; i++)
         if (m_v[i] && m_reg[i] == rg && m_fp[i] == fp) mi = i;
      ev = (op >= LCLR && op <= AKEEP);
      eh = ev && (mi >= 0);
      if (op == LCLR || op == ACLR || op == INVONE) begin
         if (mi >= 0) m_v[mi] = 0;
      end else if (op == INVALL) begin
         for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      end else if (op == ALLOC || (op == LKEEP && mi < 0)) begin
         sl = mi;
         if (sl < 0)
            for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) sl = i;
         if (sl < 0) begin
            sl   = m_rr;
            m_rr = (m_rr + 1) % DEPTH;
         end
         m_v[sl] = 1; m_reg[sl] = rg; m_fp[sl] = fp; m_addr[sl] = ad; m_size[sl] = sz;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   // want: -1 use the model, 0/1 also demand that hit value
   task automatic step(input int op, input int rg, input bit fp, input longint ad, input int sz,
                       input bit sv, input longint sa, input int ss, input int want,
                       input string req);
      bit ev, eh;
      cmd_valid = (op != NONE); cmd_op = 3'(op); cmd_reg = REG_W'(rg); cmd_fp = fp;
      cmd_addr = ADDR_W'(ad); cmd_size = SIZE_W'(sz);
      st_valid = sv; st_addr = ADDR_W'(sa); st_size = SIZE_W'(ss);
      model_step(op, rg, fp, ad, sz, sv, sa, ss, ev, eh);
      if (want >= 0 && eh != bit'(want)) begin
         errors++;
         $display("FAIL %s: model hit=%0d expected %0d (op %0d reg %0d)", req, eh, want, op, rg);
      end
      @(posedge clk); #1;
      cmd_valid = 0; st_valid = 0;
      checks++;
      if (rsp_valid !== ev || rsp_hit !== eh) begin
         errors++;
         $display("FAIL %s: op %0d reg %0d fp %0d got valid=%0d hit=%0d expected valid=%0d hit=%0d",
                  req, op, rg, fp, rsp_valid, rsp_hit, ev, eh);
      end
      @(negedge clk);
   endtask

   task automatic chk(input int rg, input bit fp, input int want, input string req);
      step(AKEEP, rg, fp, 0, 0, 0, 0, 0, want, req);
   endtask

   task automatic alloc(input int rg, input bit fp, input longint ad, input int sz);
      step(ALLOC, rg, fp, ad, sz, 0, 0, 0, -1, "R2");
   endtask

   task automatic store(input longint sa, input int ss, input string req);
      step(NONE, 0, 0, 0, 0, 1, sa, ss, -1, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_v[i] = 0; m_reg[i] = 0; m_fp[i] = 0; m_addr[i] = 0; m_size[i] = 0;
      end
      m_rr = 0;
      rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_reg = 0; cmd_fp = 0; cmd_addr = 0;
      cmd_size = 0; st_valid = 0; st_addr = 0; st_size = 0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset response got %0d/%0d expected 0/0", rsp_valid, rsp_hit);
      end
      @(negedge clk); rst_n = 1;
      @(negedge clk);

      // R1: empty table misses
      chk(5, 0, 0, "R1");
      chk(5, 1, 0, "R1");

      // R2: key is register number plus class
      alloc(5, 0, 'h100, 3);
      chk(5, 0, 1, "R2");
      chk(5, 1, 0, "R2");
      alloc(5, 1, 'h200, 2);
      chk(5, 1, 1, "R2");

      // R3: clearing load check
      step(LCLR, 5, 0, 0, 0, 0, 0, 0, 1, "R3");
      step(LCLR, 5, 0, 0, 0, 0, 0, 0, 0, "R3");
      chk(5, 0, 0, "R3");

      // R4: keeping load check allocates on miss, keeps on hit
      step(LKEEP, 9, 0, 'h300, 2, 0, 0, 0, 0, "R4");
      step(LKEEP, 9, 0, 'h300, 2, 0, 0, 0, 1, "R4");
      chk(9, 0, 1, "R4");

      // R6: clearing speculation check
      step(ACLR, 9, 0, 0, 0, 0, 0, 0, 1, "R6");
      chk(9, 0, 0, "R6");
      step(ACLR, 20, 0, 0, 0, 0, 0, 0, 0, "R6");
      chk(20, 0, 0, "R6");

      // R5: keeping speculation check never changes the table
      chk(30, 0, 0, "R5");
      chk(30, 0, 0, "R5");
      chk(5, 1, 1, "R5");
      chk(5, 1, 1, "R5");

      // R7: overlap detection, adjacent bytes survive
      alloc(1, 0, 'h400, 2);
      store('h404, 0, "R7");
      chk(1, 0, 1, "R7");
      store('h3FC, 2, "R7");
      chk(1, 0, 1, "R7");
      store('h403, 0, "R7");
      chk(1, 0, 0, "R7");
      alloc(2, 0, 'h500, 0);
      store('h4FC, 3, "R7");
      chk(2, 0, 0, "R7");

      // R8: store in same cycle as a check wins
      alloc(3, 0, 'h600, 3);
      step(LCLR, 3, 0, 0, 0, 1, 'h604, 0, 0, "R8");
      alloc(4, 0, 'h700, 2);
      step(LKEEP, 4, 0, 'h700, 2, 1, 'h700, 0, 0, "R8");
      chk(4, 0, 1, "R8");
      step(ALLOC, 11, 0, 'h800, 2, 1, 'h800, 0, -1, "R8");
      chk(11, 0, 1, "R8");

      // R10: invalidate one
      alloc(6, 0, 'hA00, 0);
      alloc(6, 1, 'hA10, 0);
      alloc(7, 0, 'hA20, 0);
      step(INVONE, 6, 0, 0, 0, 0, 0, 0, -1, "R10");
      chk(6, 0, 0, "R10");
      chk(6, 1, 1, "R10");
      chk(7, 0, 1, "R10");

      // R9: invalidate all
      step(INVALL, 0, 0, 0, 0, 0, 0, 0, -1, "R9");
      chk(6, 1, 0, "R9");
      chk(7, 0, 0, "R9");
      chk(5, 1, 0, "R9");

      // R12: reuse rewrites every field
      alloc(8, 0, 'hB00, 3);
      alloc(8, 0, 'hC00, 0);
      store('hB00, 3, "R12");
      chk(8, 0, 1, "R12");
      store('hC00, 0, "R12");
      chk(8, 0, 0, "R12");

      // R11: no duplicate after reallocation
      alloc(8, 0, 'hD00, 1);
      alloc(8, 0, 'hD00, 1);
      step(LCLR, 8, 0, 0, 0, 0, 0, 0, 1, "R11");
      chk(8, 0, 0, "R11");

      // R11: free slots then round-robin victims
      step(INVALL, 0, 0, 0, 0, 0, 0, 0, -1, "R11");
      for (int r = 40; r < 56; r++) alloc(r, 0, 'h1000 + r * 16, 0);
      alloc(60, 0, 'h2000, 0);
      chk(40, 0, 0, "R11");
      chk(41, 0, 1, "R11");
      chk(60, 0, 1, "R11");
      alloc(61, 0, 'h2010, 0);
      chk(41, 0, 0, "R11");
      chk(42, 0, 1, "R11");
      step(INVONE, 50, 0, 0, 0, 0, 0, 0, -1, "R11");
      alloc(62, 0, 'h2020, 0);
      chk(42, 0, 1, "R11");
      alloc(63, 0, 'h2030, 0);
      chk(42, 0, 0, "R11");
      chk(43, 0, 1, "R11");
      chk(62, 0, 1, "R11");

      // R13: non-check commands give no response
      step(NONE, 0, 0, 0, 0, 0, 0, 0, -1, "R13");
      alloc(70, 1, 'h3000, 1);

      // R13: random mix on both channels against the model
      for (int n = 0; n < 3000; n++) begin
         int op;
         op = int'($urandom_range(0, 7));
         if ($urandom_range(0, 15) == 0) op = NONE;
         if (op == INVALL && $urandom_range(0, 3) != 0) op = ALLOC;
         step(op, int'($urandom_range(0, 23)), bit'($urandom_range(0, 1)),
              longint'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
              bit'($urandom_range(0, 2) == 0), longint'($urandom_range(0, 255)),
              int'($urandom_range(0, 3)), -1, "R13");
      end

      finish_run();
   end

endmodule